// File: doc/BRIEF.md
# Four-Channel Current-DAC Setting Target on I2C

This block is an I2C target that holds the setting registers for four current DACs. A fast system clock samples SCL and SDA. The block recognises START, repeated START and STOP conditions. It responds to one 7-bit device address, and two strap inputs select that address. A controller writes a register with a three-byte transfer: the device address, the memory address, then one data byte. To read a register, the controller first sends the memory address in a write phase, then issues a repeated START followed by the device address with the read bit set.

Each register holds a sign bit and a 7-bit magnitude. The block decodes every register into a sink-enable flag, a source-enable flag and the magnitude. The analog current stage downstream uses these signals. SDA is open-drain: the block only ever pulls the line low, through `sda_oe`.

Top module: `cdac_i2c_target`

## Requirements
- R1: The device address is {strap_hi, strap_lo, 1, 0, 0, 0, 0}. The first byte after a START carries this address in bits 7:1 and R/W in bit 0, where 0 means write. On a matching write, the target ACKs (pulls SDA low in the ninth clock) the address byte, the memory-address byte and the data byte.
- R2: If the address byte does not match, the target gives no ACK. It then ignores all traffic, including later bytes and STOP-framed data, until the next START.
- R3: Memory addresses F8h, F9h, FAh and FBh select channels 0, 1, 2 and 3. Channel i uses bit i of `sink_en` and `source_en` and bits [7i+6:7i] of `magnitude`.
- R4: Register bit 7 is the sign and bits 6:0 are the magnitude. With a non-zero magnitude, sign 0 raises only sink_en and sign 1 raises only source_en. The sink and source enables of a channel are never high together.
- R5: A magnitude of 0 holds both enables of that channel low, whatever the sign bit is.
- R6: After reset, every register reads 00h, all enables and magnitudes are 0, and SDA is released.
- R7: A read through a repeated START returns the addressed register MSB first, one bit per SCL clock.
- R8: A write to a memory address outside F8h–FBh is ACKed but changes no register. A read from such an address returns 00h.
- R9: A register changes only when the data byte's ACK clock ends. A transfer that stops before that point leaves every register as it was.
- R10: The target changes SDA only while SCL is low, after a falling edge. It never changes SDA while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_hi | input | 1 | Device address bit 6 |
| strap_lo | input | 1 | Device address bit 5 |
| sink_en | output | 4 | Per-channel sink enable |
| source_en | output | 4 | Per-channel source enable |
| magnitude | output | 28 | Per-channel 7-bit magnitude, channel 0 in the low bits |

## Verification
Both bus lines pass through two synchronizer flops, and the bus engine then registers its response. An ACK or read bit therefore appears on `sda_oe` three to four system clocks after the SCL edge that calls for it. The bench holds each SCL phase for 20 system clocks and samples SDA in the middle of the high phase, well after the line has settled. A committed register reaches the channel outputs within about five clocks of the SCL fall that ends the data ACK. The bench checks the outputs only after the STOP and a further 20-clock margin, always on the falling system-clock edge.

// File: rtl/cdac_pkg.sv
package cdac_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACK_ADDR, ST_MEM, ST_ACK_MEM,
    ST_WDATA, ST_ACK_DATA, ST_RDATA, ST_RACK, ST_IGNORE
  } bus_st_t;

  // 7-bit device address: two straps on top, fixed 10000b below
  function automatic logic [6:0] dev_address(input logic hi, input logic lo);
    return {hi, lo, 5'b10000};
  endfunction

  // true when a lies in [base, base+n)
  function automatic logic in_window(input logic [7:0] a, input logic [7:0] base,
                                     input int unsigned n);
    logic [8:0] a9, b9;
    a9 = {1'b0, a};
    b9 = {1'b0, base};
    return (a9 >= b9) && (a9 < b9 + 9'(n));
  endfunction

  function automatic logic drive_sink(input logic [7:0] r);
    return ~r[7] & (|r[6:0]);
  endfunction

  function automatic logic drive_source(input logic [7:0] r);
    return r[7] & (|r[6:0]);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s,
  output logic line_q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= line_i;
  end

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[k] <= 1'b1;
        else        chain[k] <= chain[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= chain[STAGES-1];
  end

  assign line_s = chain[STAGES-1];
endmodule

// File: rtl/cdac_i2c_engine.sv
module cdac_i2c_engine
  import cdac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       scl_q,
  input  logic       sda_s,
  input  logic       sda_q,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [7:0] mem_ptr,
  output logic [7:0] wr_data,
  output logic       start_evt,
  output logic       stop_evt
);
  bus_st_t    state;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic [7:0] tx;
  logic       rw;
  logic       scl_rise, scl_fall;

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      mem_ptr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        state <= ST_ADDR;
        cnt   <= '0;
      end else if (stop_evt) begin
        state <= ST_IDLE;
      end else if (scl_rise) begin
        unique case (state)
          ST_ADDR, ST_MEM, ST_WDATA:
            if (cnt < 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end
          ST_RDATA: cnt <= cnt + 4'd1;
          ST_RACK:  state <= ST_IGNORE;
          default: ;
        endcase
      end else if (scl_fall) begin
        sda_oe <= 1'b0;
        unique case (state)
          ST_ADDR:
            if (cnt == 4'd8) begin
              if (shreg[7:1] == dev_addr) begin
                rw     <= shreg[0];
                sda_oe <= 1'b1;
                state  <= ST_ACK_ADDR;
              end else begin
                state <= ST_IGNORE;
              end
            end
          ST_ACK_ADDR: begin
            cnt <= '0;
            if (rw) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= ST_RDATA;
            end else begin
              state <= ST_MEM;
            end
          end
          ST_MEM:
            if (cnt == 4'd8) begin
              mem_ptr <= shreg;
              sda_oe  <= 1'b1;
              state   <= ST_ACK_MEM;
            end
          ST_ACK_MEM: begin
            cnt   <= '0;
            state <= ST_WDATA;
          end
          ST_WDATA:
            if (cnt == 4'd8) begin
              wr_data <= shreg;
              sda_oe  <= 1'b1;
              state   <= ST_ACK_DATA;
            end
          ST_ACK_DATA: begin
            wr_stb <= 1'b1;
            state  <= ST_IGNORE;
          end
          ST_RDATA:
            if (cnt == 4'd8) state  <= ST_RACK;
            else             sda_oe <= ~tx[3'd7 - cnt[2:0]];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cdac_reg_bank.sv
module cdac_reg_bank
  import cdac_pkg::*;
#(
  parameter int          NCH      = 4,
  parameter int          MAG_W    = 7,
  parameter logic [7:0]  MAP_BASE = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [7:0]           wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [7:0]           rd_addr,
  output logic [7:0]           rd_data,
  output logic [NCH-1:0]       sink_en,
  output logic [NCH-1:0]       source_en,
  output logic [NCH*MAG_W-1:0] magnitude
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [7:0] regs [NCH];
  logic [8:0] wr_off, rd_off;
  logic       wr_hit, rd_hit;

  assign wr_off = {1'b0, wr_addr} - {1'b0, MAP_BASE};
  assign rd_off = {1'b0, rd_addr} - {1'b0, MAP_BASE};
  assign wr_hit = in_window(wr_addr, MAP_BASE, NCH);
  assign rd_hit = in_window(rd_addr, MAP_BASE, NCH);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs[c] <= '0;
        else if (wr_stb && wr_hit && (wr_off[IDX_W-1:0] == IDX_W'(c)))
          regs[c] <= wr_data;
      end
      assign sink_en[c]                   = drive_sink(regs[c]);
      assign source_en[c]                 = drive_source(regs[c]);
      assign magnitude[c*MAG_W +: MAG_W]  = regs[c][MAG_W-1:0];
    end
  endgenerate

  assign rd_data = rd_hit ? regs[rd_off[IDX_W-1:0]] : 8'h00;
endmodule

// File: rtl/cdac_i2c_target.sv
module cdac_i2c_target #(
  parameter int         NCH         = 4,
  parameter int         MAG_W       = 7,
  parameter logic [7:0] MAP_BASE    = 8'hF8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe,
  input  logic                 strap_hi,
  input  logic                 strap_lo,
  output logic [NCH-1:0]       sink_en,
  output logic [NCH-1:0]       source_en,
  output logic [NCH*MAG_W-1:0] magnitude
);
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       start_evt, stop_evt, wr_stb;
  logic [7:0] mem_ptr, wr_data, rd_data;
  logic [6:0] dev_addr;

  assign dev_addr = cdac_pkg::dev_address(strap_hi, strap_lo);

  i2c_line_sync #(.STAGES(SYNC_STAGES)) scl_sync_i (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_s(scl_s), .line_q(scl_q));
  i2c_line_sync #(.STAGES(SYNC_STAGES)) sda_sync_i (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_s(sda_s), .line_q(sda_q));

  cdac_i2c_engine engine_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_q(scl_q), .sda_s(sda_s),
    .sda_q(sda_q), .dev_addr(dev_addr), .rd_data(rd_data), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .mem_ptr(mem_ptr), .wr_data(wr_data),
    .start_evt(start_evt), .stop_evt(stop_evt));

  cdac_reg_bank #(.NCH(NCH), .MAG_W(MAG_W), .MAP_BASE(MAP_BASE)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(mem_ptr),
    .wr_data(wr_data), .rd_addr(mem_ptr), .rd_data(rd_data),
    .sink_en(sink_en), .source_en(source_en), .magnitude(magnitude));
endmodule

// File: rtl/cdac_i2c_checker.sv
module cdac_i2c_checker #(
  parameter int         NCH      = 4,
  parameter int         MAG_W    = 7,
  parameter logic [7:0] MAP_BASE = 8'hF8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 scl_s,
  input logic                 scl_q,
  input logic                 sda_oe,
  input logic                 wr_stb,
  input logic [7:0]           mem_ptr,
  input logic [NCH-1:0]       sink_en,
  input logic [NCH-1:0]       source_en,
  input logic [NCH*MAG_W-1:0] magnitude
);
  assert_sda_quiet_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q) |-> $stable(sda_oe));

  assert_commit_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(magnitude) && $stable(sink_en) && $stable(source_en)));

  assert_commit_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_outside_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !cdac_pkg::in_window(mem_ptr, MAP_BASE, NCH)) |=>
      ($stable(magnitude) && $stable(sink_en) && $stable(source_en)));

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assert_one_direction_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sink_en[c], source_en[c]}) <= 1);
      assert_zero_mag_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (magnitude[c*MAG_W +: MAG_W] == '0) |-> (!sink_en[c] && !source_en[c]));
    end
  endgenerate
endmodule

bind cdac_i2c_target cdac_i2c_checker #(.NCH(NCH), .MAG_W(MAG_W), .MAP_BASE(MAP_BASE)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_q(scl_q), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .mem_ptr(mem_ptr), .sink_en(sink_en), .source_en(source_en),
  .magnitude(magnitude));

// File: tb/cdac_i2c_target_tb.sv
`timescale 1ns/1ps
module cdac_i2c_target_tb_top;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic tb_low = 1'b0;
  logic strap_hi = 1'b0, strap_lo = 1'b0;
  logic sda_oe;
  logic [3:0] sink_en, source_en;
  logic [27:0] magnitude;
  wire sda_line = ~(tb_low | sda_oe);

  int checks = 0, bad = 0;
  logic [7:0] model [4];

  always #2 clk = ~clk;

  cdac_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_hi(strap_hi), .strap_lo(strap_lo), .sink_en(sink_en),
    .source_en(source_en), .magnitude(magnitude));

  // {is_read, memory address, data written / data expected}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'hF8, 8'hAA}, {1'b1, 8'hF8, 8'hAA}, {1'b0, 8'hF9, 8'h05},
    {1'b0, 8'hFA, 8'h80}, {1'b0, 8'hFB, 8'hFF}, {1'b0, 8'h7C, 8'h55},
    {1'b1, 8'h7C, 8'h00}, {1'b1, 8'hFB, 8'hFF}};

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(input string req);
    logic [3:0] es, eo;
    logic [27:0] em;
    wait_h(H);
    for (int c = 0; c < 4; c++) begin
      es[c] = (model[c][6:0] != 0) && !model[c][7];
      eo[c] = (model[c][6:0] != 0) &&  model[c][7];
      em[c*7 +: 7] = model[c][6:0];
    end
    chk({req, " sink"}, 32'(sink_en), 32'(es));
    chk({req, " source"}, 32'(source_en), 32'(eo));
    chk({req, " mag"}, 32'(magnitude), 32'(em));
  endtask

  task automatic bus_start();
    tb_low = 1'b0; wait_h(H); scl = 1'b1; wait_h(H);
    tb_low = 1'b1; wait_h(H); scl = 1'b0;
  endtask

  task automatic bus_stop();
    tb_low = 1'b1; wait_h(H); scl = 1'b1; wait_h(H); tb_low = 1'b0; wait_h(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      tb_low = ~b[i]; wait_h(H); scl = 1'b1; wait_h(H); scl = 1'b0;
    end
    tb_low = 1'b0; wait_h(H); scl = 1'b1; wait_h(H/2);
    acked = ~sda_line; wait_h(H/2); scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b);
    tb_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wait_h(H); scl = 1'b1; wait_h(H/2); b[i] = sda_line; wait_h(H/2); scl = 1'b0;
    end
    wait_h(H); scl = 1'b1; wait_h(H); scl = 1'b0;   // NACK: line left released
  endtask

  task automatic do_write(input logic [7:0] dev, input logic [7:0] a, input logic [7:0] d,
                          output logic [2:0] acks);
    bus_start();
    send_byte(dev, acks[2]); send_byte(a, acks[1]); send_byte(d, acks[0]);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] dev, input logic [7:0] a,
                         output logic [7:0] d, output logic [2:0] acks);
    bus_start();
    send_byte(dev, acks[2]); send_byte(a, acks[1]);
    bus_start();                                     // repeated START
    send_byte(dev | 8'h01, acks[0]);
    recv_byte(d);
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin : main
    logic [2:0] acks;
    logic [7:0] rd;
    logic dummy;
    for (int c = 0; c < 4; c++) model[c] = 8'h00;
    wait_h(5);
    // R6: reset state
    chk("R6 oe in reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    chk_outputs("R6 reset");
    do_read(8'h20, 8'hFA, rd, acks);
    chk("R6 reset readback", 32'(rd), 0);

    for (int v = 0; v < 8; v++) begin
      if (VEC[v][16]) begin
        do_read(8'h20, VEC[v][15:8], rd, acks);
        chk("R7 R8 read data", 32'(rd), 32'(VEC[v][7:0]));
        chk("R1 read acks", 32'(acks), 32'h7);
      end else begin
        do_write(8'h20, VEC[v][15:8], VEC[v][7:0], acks);
        chk("R1 R8 write acks", 32'(acks), 32'h7);
        if (VEC[v][15:8] >= 8'hF8) model[VEC[v][15:8] - 8'hF8] = VEC[v][7:0];
      end
      chk_outputs("R3 R4 R5 R8 table");
    end

    // R5: sink sign with zero magnitude
    do_write(8'h20, 8'hF9, 8'h00, acks);
    model[1] = 8'h00;
    chk_outputs("R5 zero sink");

    // R2: wrong device address, no ACK, data ignored
    do_write(8'h60, 8'hF8, 8'h11, acks);
    chk("R2 nack", 32'(acks[2]), 0);
    chk_outputs("R2 ignored");

    // R1: other strap setting moves the address to E0h
    strap_hi = 1'b1; strap_lo = 1'b1;
    wait_h(4);
    do_write(8'hE0, 8'hF9, 8'h83, acks);
    chk("R1 strap acks", 32'(acks), 32'h7);
    model[1] = 8'h83;
    chk_outputs("R1 strap write");
    do_write(8'h20, 8'hF9, 8'h01, acks);
    chk("R1 old address rejected", 32'(acks[2]), 0);
    chk_outputs("R1 old address");

    // R9: STOP in the middle of the data byte
    bus_start();
    send_byte(8'hE0, dummy); send_byte(8'hF8, dummy);
    for (int i = 7; i >= 4; i--) begin
      tb_low = 1'b0; wait_h(H); scl = 1'b1; wait_h(H); scl = 1'b0;
    end
    bus_stop();
    chk_outputs("R9 abort");

    // R10 checked by its assertion during the reads above; read once more
    do_read(8'hE0, 8'hF9, rd, acks);
    chk("R7 R10 read after abort", 32'(rd), 32'h83);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule